// File: doc/BRIEF.md
# Remote Terminal Built-In-Test Register

This block holds the 16-bit built-in-test word of a MIL-STD-1553B remote terminal. The terminal's decoder, protocol engine and transmitter report what they see as one-cycle strobes: a validated command, together with its T/R bit, broadcast flag, mode-command flag and mode code, plus separate error events. Each bit of the word follows its own rule. Some bits are cleared by every ordinary command. Some stay set until a reset. Some simply mirror a level input. The word is presented continuously on `bit_word`, so the protocol engine can transmit it when asked.

Encoding, transceivers and full message decoding sit outside the block. A decoded command appears as `cmd_valid` with its attributes. `cmd_mode` is high when the subaddress field marks a mode command. A built-in self-test window is timed by an internal counter of `ST_WINDOW` clock cycles.

Top module: `rt_bit_reg`

## Requirements
- R1: Power-up reset (`rst_n` low) clears every latched bit, so `bit_word` reads 0 when the level inputs are low.
- R2: The layout of `bit_word` is as follows. Bit 0 is transmitter timeout error, bit 1 handshake failure, bit 2 loop test failure, bit 3 illegal T/R, bit 4 illegal command, bit 5 word count low, bit 6 word count high, bit 7 illegal broadcast, bits 12 and 13 timeout on bus 0 and bus 1. Bits 8, 9 and 11 equal `bus0_off`, `bus1_off` and `tflag_inh` in the same cycle. Bits 10, 14 and 15 read 0.
- R3: A `cmd_valid` clears bits 3 to 7 at the next edge, unless it is a mode command with code 2, 18 or 19.
- R4: A mode command with code 2, 18 or 19 leaves the register unchanged.
- R5: A legal reset-terminal command (mode code 8 with `ss_cmd_ok` high) clears bits 0 to 7, 12 and 13. The live bits are not affected.
- R6: Bit 7 sets when a broadcast `cmd_valid` requires a transmission. A transmission is required by a non-mode command with `cmd_tx`=1, or by a mode command with `cmd_tx`=1 and code 2, 16, 18 or 19. A broadcast receive command leaves bit 7 clear.
- R7: Bit 4 sets in three cases: a non-preserved `cmd_valid` arrives with `ss_cmd_ok` low; a mode command with a reserved code (9 to 15 or 22 to 31) arrives while `rsvd_chk` is high; or `ev_bad_shdn` pulses. A reserved code with `rsvd_chk` low does not set it.
- R8: The pulses `ev_bad_tr`, `ev_wc_low`, `ev_wc_high`, `ev_loop_err` and `ev_hs_fail` set bits 3, 5, 6, 2 and 1. Bits 1 and 2 survive ordinary commands.
- R9: When a set and a clear of the same bit fall in one cycle, the set wins.
- R10: Outside a self-test, `ev_tto_b0` or `ev_tto_b1` sets bit 12 or bit 13 and also sets bit 0.
- R11: A legal mode code 3 starts a self-test window. If no timeout pulse arrives within `ST_WINDOW` cycles, bit 0 sets when the window ends. If a timeout pulse arrives inside the window, the window closes and only the matching bus bit sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a validated command word |
| cmd_tx | input | 1 | T/R bit of the command (1 = terminal transmits) |
| cmd_bcast | input | 1 | Command carries the broadcast address |
| cmd_mode | input | 1 | Command is a mode command |
| cmd_code | input | 5 | Mode code of the command |
| ss_cmd_ok | input | 1 | Subsystem legality input; low marks the command illegal |
| rsvd_chk | input | 1 | When high, reserved mode codes are treated as illegal |
| ev_bad_tr | input | 1 | Illegal T/R event |
| ev_wc_low | input | 1 | Too few data words event |
| ev_wc_high | input | 1 | Too many data words event |
| ev_loop_err | input | 1 | Own transmission absent or corrupted |
| ev_hs_fail | input | 1 | Subsystem handshake failure |
| ev_bad_shdn | input | 1 | Illegal transmitter shutdown command |
| ev_tto_b0 | input | 1 | Transmitter timeout tripped on bus 0 |
| ev_tto_b1 | input | 1 | Transmitter timeout tripped on bus 1 |
| bus0_off | input | 1 | Bus 0 transmitter is shut down (level) |
| bus1_off | input | 1 | Bus 1 transmitter is shut down (level) |
| tflag_inh | input | 1 | Terminal flag is inhibited (level) |
| bit_word | output | 16 | Current built-in-test word |

## Verification
The bench steps through a command sequence in which clears and sets land in the same cycle. A design that let the clear win would lose a word-count or handshake error reported during a new command. It issues the three preserving mode codes after illegal-broadcast has been set; a design that treated them as ordinary commands would wipe bit 7. It drives a reserved code with the check input both high and low, a broadcast receive, and a reset-terminal command both with and without subsystem approval, so a design that cleared on an illegal reset or flagged legal broadcasts would be caught. It runs the self-test window both with and without a timeout trip. A design with an off-by-a-lot window, or one that flagged an expected trip as an error, would show bit 0 in the wrong case.

// File: rtl/rt_bit_reg.sv
module rt_bit_reg #(
  parameter int ST_WINDOW = 9600,
  localparam int STW = $clog2(ST_WINDOW + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_tx,
  input  logic        cmd_bcast,
  input  logic        cmd_mode,
  input  logic [4:0]  cmd_code,
  input  logic        ss_cmd_ok,
  input  logic        rsvd_chk,
  input  logic        ev_bad_tr,
  input  logic        ev_wc_low,
  input  logic        ev_wc_high,
  input  logic        ev_loop_err,
  input  logic        ev_hs_fail,
  input  logic        ev_bad_shdn,
  input  logic        ev_tto_b0,
  input  logic        ev_tto_b1,
  input  logic        bus0_off,
  input  logic        bus1_off,
  input  logic        tflag_inh,
  output logic [15:0] bit_word
);

  localparam logic [31:0] KEEP_CODES = 32'h000C_0004;
  localparam logic [31:0] RSVD_CODES = 32'hFFC0_FE00;
  localparam logic [31:0] TXDAT_CODES = 32'h000D_0004;
  localparam logic [4:0]  MC_SELFTEST = 5'd3;
  localparam logic [4:0]  MC_RESET = 5'd8;

  logic [7:0]     lat;
  logic [1:0]     tto_bus;
  logic           st_on;
  logic [STW-1:0] st_cnt;

  logic [31:0] code_hot;
  logic is_mc, keep, rt_reset, wants_tx, clr_cmd, trip;
  logic st_start, st_expire;
  logic [7:0] set_v, clr_v;

  assign code_hot  = 32'd1 << cmd_code;
  assign is_mc     = cmd_valid & cmd_mode;
  assign keep      = is_mc & |(code_hot & KEEP_CODES);
  assign rt_reset  = is_mc & (cmd_code == MC_RESET) & ss_cmd_ok;
  assign wants_tx  = cmd_tx & (~cmd_mode | |(code_hot & TXDAT_CODES));
  assign clr_cmd   = cmd_valid & ~keep;
  assign trip      = ev_tto_b0 | ev_tto_b1;
  assign st_start  = is_mc & (cmd_code == MC_SELFTEST) & ss_cmd_ok;
  assign st_expire = st_on & (st_cnt == STW'(ST_WINDOW - 1)) & ~trip;

  always_comb begin
    set_v[0] = st_expire | (~st_on & trip);
    set_v[1] = ev_hs_fail;
    set_v[2] = ev_loop_err;
    set_v[3] = ev_bad_tr;
    set_v[4] = ev_bad_shdn |
               (clr_cmd & (~ss_cmd_ok | (rsvd_chk & cmd_mode & |(code_hot & RSVD_CODES))));
    set_v[5] = ev_wc_low;
    set_v[6] = ev_wc_high;
    set_v[7] = clr_cmd & cmd_bcast & wants_tx;
    clr_v    = {{5{clr_cmd | rt_reset}}, {3{rt_reset}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat     <= '0;
      tto_bus <= '0;
    end else begin
      lat     <= (lat & ~clr_v) | set_v;
      tto_bus <= (tto_bus & {2{~rt_reset}}) | {ev_tto_b1, ev_tto_b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_on  <= 1'b0;
      st_cnt <= '0;
    end else if (st_start) begin
      st_on  <= 1'b1;
      st_cnt <= '0;
    end else if (st_on) begin
      if (trip || st_expire || rt_reset) st_on <= 1'b0;
      st_cnt <= st_cnt + 1'b1;
    end
  end

  assign bit_word = {2'b00, tto_bus, tflag_inh, 1'b0, bus1_off, bus0_off, lat};

endmodule

module rt_bit_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_tx,
  input logic        cmd_bcast,
  input logic        cmd_mode,
  input logic [4:0]  cmd_code,
  input logic        ss_cmd_ok,
  input logic        rsvd_chk,
  input logic        ev_bad_tr,
  input logic        ev_wc_low,
  input logic        ev_wc_high,
  input logic        ev_loop_err,
  input logic        ev_hs_fail,
  input logic        ev_bad_shdn,
  input logic        ev_tto_b0,
  input logic        ev_tto_b1,
  input logic        bus0_off,
  input logic        bus1_off,
  input logic        tflag_inh,
  input logic [15:0] bit_word
);
  logic quiet, keep_cmd;
  assign quiet = ~(ev_bad_tr | ev_wc_low | ev_wc_high | ev_loop_err | ev_hs_fail |
                   ev_bad_shdn | ev_tto_b0 | ev_tto_b1);
  assign keep_cmd = cmd_valid & cmd_mode &
                    (cmd_code == 5'd2 || cmd_code == 5'd18 || cmd_code == 5'd19);

  p_live_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_word[8] == bus0_off && bit_word[9] == bus1_off && bit_word[11] == tflag_inh &&
    bit_word[10] == 1'b0 && bit_word[15:14] == 2'b00);

  p_plain_cmd_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_mode && !cmd_tx && ss_cmd_ok && quiet |=> bit_word[7:3] == 5'd0);

  p_keep_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    keep_cmd && quiet |=> bit_word[7:1] == $past(bit_word[7:1]) &&
                          bit_word[13:12] == $past(bit_word[13:12]));

  p_rt_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_mode && cmd_code == 5'd8 && ss_cmd_ok && quiet
    |=> bit_word[7:1] == 7'd0 && bit_word[13:12] == 2'b00);

  p_bcast_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_bcast && cmd_tx && !cmd_mode |=> bit_word[7]);

  p_bad_shdn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_shdn |=> bit_word[4]);

  p_hs_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_word[1] && !(cmd_valid && cmd_mode && cmd_code == 5'd8 && ss_cmd_ok) |=> bit_word[1]);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wc_low |=> bit_word[5]);

  p_bus_tto_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tto_b0 |=> bit_word[12]);
endmodule

bind rt_bit_reg rt_bit_reg_chk u_chk (.*);

// File: tb/sim_rt_bit_reg.sv
module sim_rt_bit_reg;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_tx = 0, cmd_bcast = 0, cmd_mode = 0;
  logic [4:0] cmd_code = '0;
  logic ss_cmd_ok = 1, rsvd_chk = 0;
  logic ev_bad_tr = 0, ev_wc_low = 0, ev_wc_high = 0, ev_loop_err = 0, ev_hs_fail = 0;
  logic ev_bad_shdn = 0, ev_tto_b0 = 0, ev_tto_b1 = 0;
  logic bus0_off = 0, bus1_off = 0, tflag_inh = 0;
  logic [15:0] bit_word;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  rt_bit_reg #(.ST_WINDOW(WIN)) u0 (.*);

  typedef struct packed {
    logic cv, tx, bc, md;
    logic [4:0] code;
    logic ok, rchk;
    logic [7:0] ev;
    logic [15:0] exp;
  } vec_t;

  // ev order: bad_tr wc_low wc_high loop_err hs_fail bad_shdn tto_b0 tto_b1
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b10000000,16'h0008}, // R8
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b01100000,16'h0068}, // R8
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00000000,16'h0000}, // R3
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00011000,16'h0006}, // R8
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b01000000,16'h0026}, // R9
    '{1'b1,1'b1,1'b1,1'b0,5'd0, 1'b1,1'b0,8'b00000000,16'h0086}, // R6
    '{1'b1,1'b1,1'b0,1'b1,5'd2, 1'b1,1'b0,8'b00000000,16'h0086}, // R4
    '{1'b1,1'b1,1'b0,1'b1,5'd18,1'b1,1'b0,8'b00000000,16'h0086}, // R4
    '{1'b1,1'b1,1'b0,1'b1,5'd19,1'b1,1'b0,8'b00000000,16'h0086}, // R4
    '{1'b1,1'b0,1'b1,1'b1,5'd17,1'b1,1'b0,8'b00000000,16'h0006}, // R6
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 1'b0,1'b0,8'b00000000,16'h0016}, // R7
    '{1'b1,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00000000,16'h0006}, // R3
    '{1'b1,1'b1,1'b0,1'b1,5'd9, 1'b1,1'b1,8'b00000000,16'h0016}, // R7
    '{1'b1,1'b1,1'b0,1'b1,5'd9, 1'b1,1'b0,8'b00000000,16'h0006}, // R7
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00000100,16'h0016}, // R7
    '{1'b1,1'b1,1'b1,1'b1,5'd16,1'b1,1'b0,8'b00000000,16'h0086}, // R6
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00000010,16'h1087}, // R10
    '{1'b0,1'b0,1'b0,1'b0,5'd0, 1'b1,1'b0,8'b00000001,16'h3087}, // R10
    '{1'b1,1'b0,1'b0,1'b1,5'd8, 1'b1,1'b0,8'b00000000,16'h0000}, // R5
    '{1'b1,1'b0,1'b0,1'b1,5'd8, 1'b1,1'b0,8'b00001000,16'h0002}, // R9
    '{1'b1,1'b0,1'b0,1'b1,5'd8, 1'b0,1'b0,8'b00000000,16'h0012}  // R5
  };

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (bit_word !== exp) begin
      errors++;
      $display("FAIL %s: bit_word=%h expected=%h", req, bit_word, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    cmd_valid = v.cv; cmd_tx = v.tx; cmd_bcast = v.bc; cmd_mode = v.md;
    cmd_code = v.code; ss_cmd_ok = v.ok; rsvd_chk = v.rchk;
    {ev_bad_tr, ev_wc_low, ev_wc_high, ev_loop_err, ev_hs_fail,
     ev_bad_shdn, ev_tto_b0, ev_tto_b1} = v.ev;
    @(negedge clk);
    cmd_valid = 0; cmd_tx = 0; cmd_bcast = 0; cmd_mode = 0; cmd_code = '0;
    ss_cmd_ok = 1; rsvd_chk = 0;
    {ev_bad_tr, ev_wc_low, ev_wc_high, ev_loop_err, ev_hs_fail,
     ev_bad_shdn, ev_tto_b0, ev_tto_b1} = '0;
  endtask

  task automatic power_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 after power-up", 16'h0000);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      checks++;
      if (bit_word !== TBL[i].exp) begin
        errors++;
        $display("FAIL R2-layout vector %0d (see tag in table): bit_word=%h expected=%h",
                 i, bit_word, TBL[i].exp);
      end
    end

    // R2: live level bits
    bus0_off = 1; tflag_inh = 1; #1;
    check("R2 bus0/tflag live", 16'h0912);
    bus1_off = 1; #1;
    check("R2 bus1 live", 16'h0B12);
    bus0_off = 0; tflag_inh = 0;
    drive('{1'b1,1'b0,1'b0,1'b1,5'd8,1'b1,1'b0,8'b0,16'h0});
    check("R5 reset-terminal keeps live bit", 16'h0200);
    bus1_off = 0; #1;
    check("R2 live bit drops", 16'h0000);

    // R1: power reset clears latched content
    drive('{1'b0,1'b0,1'b0,1'b0,5'd0,1'b1,1'b0,8'b11111111,16'h0});
    power_reset();
    check("R1 power reset clears", 16'h0000);

    // R11: self-test window expires with no trip
    drive('{1'b1,1'b0,1'b0,1'b1,5'd3,1'b1,1'b0,8'b0,16'h0});
    repeat (28) @(negedge clk);
    check("R11 inside window", 16'h0000);
    repeat (17) @(negedge clk);
    check("R11 window expired", 16'h0001);
    power_reset();

    // R11: trip inside the window -> only bus bit
    drive('{1'b1,1'b0,1'b0,1'b1,5'd3,1'b1,1'b0,8'b0,16'h0});
    repeat (10) @(negedge clk);
    drive('{1'b0,1'b0,1'b0,1'b0,5'd0,1'b1,1'b0,8'b00000010,16'h0});
    check("R11 trip in window", 16'h1000);
    repeat (50) @(negedge clk);
    check("R11 no late error after trip", 16'h1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule